// File: doc/BRIEF.md
# GPIO Interrupt Status Aggregator

This block gathers the per-pin pending flags of a large GPIO bank into a compact summary and drives one shared interrupt line towards the host. Pins are grouped four at a time. A group's summary bit is set when any pin in it has its interrupt or wake status raised and is unmasked. The summary is presented as two 32-bit words. Only the low 46 bits carry groups; the rest are tied to zero.

A control register holds three things: a blocking length, a blocking enable and an end-of-interrupt strobe. After servicing, software writes the strobe. The interrupt line then drops for one cycle and comes back if work is still pending. When the blocking enable is set, a write to any pin's debounce configuration starts a global quiet window of the programmed number of clock cycles. During that window no pin can raise status, and every pin receives a force-low signal for its interrupt-enable readback.

Top module: `gpio_irq_agg`

## Requirements
- R1: One cycle after the inputs are applied, summary bit k (bit k of {sum_hi, sum_lo}) is 1 exactly when some pin p with 4k <= p <= 4k+3 has (int_sts[p] or wake_sts[p]) set together with mask[p], unless blocking applies.
- R2: A pin whose mask bit is 0 does not contribute to its summary bit, whatever its status flags.
- R3: Summary bits 46 to 63 (sum_hi[31:14]) are always 0.
- R4: irq is 1 when at least one summary bit is set and no end-of-interrupt strobe was written in the previous cycle. irq is 0 whenever the summary is all zero.
- R5: A write of cfg_wdata with bit 13 set (end of interrupt) makes irq 0 for exactly the following cycle. After that cycle irq returns to 1 if any summary bit is still set.
- R6: The control register reads back the blocking length in bits 11:0 and the blocking enable in bit 12. Bit 13 and bits 31:14 read 0, and the whole register is 0 after reset.
- R7: With the enable set and length L > 0, a cycle with db_wr high makes en_force_low all ones for the next L cycles. The summary reads all zero from the cycle after the write through the cycle after the window ends.
- R8: db_wr while the blocking enable is 0 starts no window and leaves the summary unaffected.
- R9: db_wr during an open window reloads the count, so the window ends L cycles after the latest write.
- R10: With the enable set and length 0, db_wr starts no window and leaves the summary unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_sts | input | 184 | Per-pin interrupt status flags |
| wake_sts | input | 184 | Per-pin wake status flags |
| mask | input | 184 | Per-pin unmask bits (1 = may signal) |
| db_wr | input | 1 | Strobe: a debounce configuration of some pin is being written |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 32 | Control write data: [11:0] length, [12] enable, [13] end of interrupt |
| cfg_rdata | output | 32 | Control register readback |
| sum_lo | output | 32 | Summary bits 31:0 |
| sum_hi | output | 32 | Summary bits 63:32 (only 45:32 can be nonzero) |
| irq | output | 1 | Shared interrupt line, active high |
| en_force_low | output | 184 | Per-pin force of interrupt-enable readback to 0 during blocking |

## Verification
The bench targets group boundaries: a pin at either edge of a four-pin group must light only its own bit, and a masked pin must light nothing. A wrong stride or a missed mask would show up as a neighbouring or spurious summary bit. It times the end-of-interrupt drop and reassertion to the cycle. A design that latched the drop or never released it would hold irq low. It retriggers a blocking window mid-count and issues debounce writes with the enable off or the length at zero. An off-by-one counter, a window that ignores the reload, or a spurious one-cycle blank would each leave force or summary wrong in an identifiable cycle.

// File: rtl/gia_pkg.sv
package gia_pkg;
  localparam int CFG_LEN_W  = 12;
  localparam int CFG_EN_BIT = 12;
  localparam int CFG_EOI_BIT = 13;
  localparam int SUM_BITS   = 64;

  typedef struct packed {
    logic                 blk_en;
    logic [CFG_LEN_W-1:0] blk_len;
  } gia_cfg_t;
endpackage

// File: rtl/gia_group_or.sv
module gia_group_or #(
  parameter int NUM_GROUPS     = 46,
  parameter int PINS_PER_GROUP = 4,
  localparam int NUM_PINS      = NUM_GROUPS * PINS_PER_GROUP
) (
  input  logic [NUM_PINS-1:0]   int_sts,
  input  logic [NUM_PINS-1:0]   wake_sts,
  input  logic [NUM_PINS-1:0]   mask,
  output logic [NUM_GROUPS-1:0] grp_any
);
  logic [NUM_PINS-1:0] live;

  assign live = (int_sts | wake_sts) & mask;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_any[g] = |live[g*PINS_PER_GROUP +: PINS_PER_GROUP];
  end
endmodule

// File: rtl/gia_block_timer.sv
module gia_block_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] len,
  output logic         active
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign active = (cnt_q != '0);
  assign cnt_en = start | active;

  always_comb begin
    if (start) cnt_d = len;
    else       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/gia_master_reg.sv
module gia_master_reg
  import gia_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output gia_cfg_t    cfg,
  output logic        eoi_q
);
  gia_cfg_t cfg_q, cfg_d;
  logic     eoi_d;

  always_comb begin
    cfg_d.blk_len = wdata[CFG_LEN_W-1:0];
    cfg_d.blk_en  = wdata[CFG_EN_BIT];
    eoi_d         = wr & wdata[CFG_EOI_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      eoi_q <= 1'b0;
    end else begin
      if (wr) cfg_q <= cfg_d;
      eoi_q <= eoi_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gia_pkg::*;
#(
  parameter int NUM_GROUPS     = 46,
  parameter int PINS_PER_GROUP = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] int_sts,
  input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] wake_sts,
  input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] mask,
  input  logic                                 db_wr,
  input  logic                                 cfg_wr,
  input  logic [31:0]                          cfg_wdata,
  output logic [31:0]                          cfg_rdata,
  output logic [31:0]                          sum_lo,
  output logic [31:0]                          sum_hi,
  output logic                                 irq,
  output logic [NUM_GROUPS*PINS_PER_GROUP-1:0] en_force_low
);
  localparam int NUM_PINS = NUM_GROUPS * PINS_PER_GROUP;
  localparam int PAD_BITS = SUM_BITS - NUM_GROUPS;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  gia_cfg_t cfg;
  logic     eoi_q;

  gia_master_reg u_mreg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .eoi_q (eoi_q)
  );

  logic [NUM_GROUPS-1:0] grp_any;

  gia_group_or #(
    .NUM_GROUPS     (NUM_GROUPS),
    .PINS_PER_GROUP (PINS_PER_GROUP)
  ) u_grp (
    .int_sts  (int_sts),
    .wake_sts (wake_sts),
    .mask     (mask),
    .grp_any  (grp_any)
  );

  logic blk_start, blk_active, gate;

  assign blk_start = db_wr & cfg.blk_en & (cfg.blk_len != '0);

  gia_block_timer #(.W(CFG_LEN_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (blk_start),
    .len    (cfg.blk_len),
    .active (blk_active)
  );

  // the write cycle itself is already quiet, so no status slips through
  assign gate = blk_active | blk_start;

  logic [NUM_GROUPS-1:0] sum_q, sum_d;

  always_comb begin
    sum_d = gate ? '0 : grp_any;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sum_q <= '0;
    else            sum_q <= sum_d;
  end

  logic [SUM_BITS-1:0] sum_full;

  assign sum_full     = {{PAD_BITS{1'b0}}, sum_q};
  assign sum_lo       = sum_full[31:0];
  assign sum_hi       = sum_full[63:32];
  assign irq          = (|sum_q) & ~eoi_q;
  assign en_force_low = {NUM_PINS{blk_active}};

  always_comb begin
    cfg_rdata                      = '0;
    cfg_rdata[CFG_LEN_W-1:0]       = cfg.blk_len;
    cfg_rdata[CFG_EN_BIT]          = cfg.blk_en;
  end
endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk #(
  parameter int NP = 184
) (
  input logic          clk,
  input logic          rst_n,
  input logic          db_wr,
  input logic          cfg_wr,
  input logic [31:0]   cfg_wdata,
  input logic [31:0]   cfg_rdata,
  input logic [31:0]   sum_lo,
  input logic [31:0]   sum_hi,
  input logic          irq,
  input logic [NP-1:0] en_force_low
);
  // R3
  hi_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_hi[31:14] == '0);

  // R4
  irq_needs_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((sum_lo | sum_hi) != '0));

  // R5
  eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[13]) |=> !irq);

  // R7
  window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (db_wr && cfg_rdata[12] && cfg_rdata[11:0] != '0) |=> en_force_low[0]);

  // R7
  window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_force_low[0] |=> ((sum_lo | sum_hi) == '0));

  // R7
  force_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_force_low == '0) || (en_force_low == '1));

  // R8
  no_spurious_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_force_low[0] && !(db_wr && cfg_rdata[12])) |=> !en_force_low[0]);
endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.NP(NUM_GROUPS*PINS_PER_GROUP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .db_wr        (db_wr),
  .cfg_wr       (cfg_wr),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .sum_lo       (sum_lo),
  .sum_hi       (sum_hi),
  .irq          (irq),
  .en_force_low (en_force_low)
);

// File: tb/tb_gpio_irq_agg.sv
`timescale 1ns/1ps
module tb_gpio_irq_agg;
  localparam int NG = 46;
  localparam int NP = NG * 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] int_sts, wake_sts, mask;
  logic          db_wr, cfg_wr;
  logic [31:0]   cfg_wdata;
  logic [31:0]   cfg_rdata, sum_lo, sum_hi;
  logic          irq;
  logic [NP-1:0] en_force_low;

  int total = 0;
  int bad   = 0;

  // bench model state
  logic [63:0] m_sum;
  logic [11:0] m_cnt, m_len;
  logic        m_en, m_eoi;

  always #4 clk = ~clk;

  gpio_irq_agg dut (
    .clk(clk), .rst_n(rst_n), .int_sts(int_sts), .wake_sts(wake_sts),
    .mask(mask), .db_wr(db_wr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sum_lo(sum_lo), .sum_hi(sum_hi), .irq(irq),
    .en_force_low(en_force_low)
  );

  function automatic logic [63:0] grp_fn(logic [NP-1:0] a, logic [NP-1:0] w,
                                         logic [NP-1:0] m);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < NG; k++)
      for (int j = 0; j < 4; j++)
        if ((a[4*k+j] | w[4*k+j]) & m[4*k+j]) r[k] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic start, gate;
    start = db_wr & m_en & (m_len != 0);
    gate  = (m_cnt != 0) | start;
    m_sum = gate ? 64'd0 : grp_fn(int_sts, wake_sts, mask);
    if (start)           m_cnt = m_len;
    else if (m_cnt != 0) m_cnt = m_cnt - 1'b1;
    m_eoi = cfg_wr & cfg_wdata[13];
    if (cfg_wr) begin
      m_len = cfg_wdata[11:0];
      m_en  = cfg_wdata[12];
    end
  endtask

  task automatic compare_all(string ctx);
    logic ok_force;
    ok_force = (en_force_low == {NP{m_cnt != 0}});
    chk({"R1 summary ", ctx}, {sum_hi, sum_lo}, m_sum);
    chk({"R3 pad ", ctx}, {46'd0, sum_hi[31:14]}, 64'd0);
    chk({"R4 irq ", ctx}, {63'd0, irq}, {63'd0, (m_sum != 0) & ~m_eoi});
    chk({"R7 force ", ctx}, {63'd0, ok_force}, 64'd1);
    chk({"R6 cfg ", ctx}, {32'd0, cfg_rdata}, {51'd0, m_en, m_len});
  endtask

  task automatic tick(string ctx);
    @(posedge clk);
    model_step();
    #2;
    compare_all(ctx);
    db_wr  = 1'b0;
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_write(logic [31:0] v, string ctx);
    cfg_wr = 1'b1; cfg_wdata = v;
    tick(ctx);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int win;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; int_sts = '0; wake_sts = '0; mask = '0;
    db_wr = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0;
    m_sum = '0; m_cnt = '0; m_len = '0; m_en = 1'b0; m_eoi = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R6 reset state
    chk("R6 reset cfg", {32'd0, cfg_rdata}, 64'd0);
    compare_all("reset");

    // R2 masked pin then unmasked
    int_sts[5] = 1'b1;
    tick("R2 masked");
    chk("R2 masked pin silent", {sum_hi, sum_lo}, 64'd0);
    mask[5] = 1'b1;
    tick("R2 unmasked");
    chk("R1 pin5 -> bit1", {sum_hi, sum_lo}, 64'd2);
    // group edges: pin 4k+3 and pin 4(k+1)
    int_sts = '0; mask = '0;
    wake_sts[183] = 1'b1; mask[183] = 1'b1; wake_sts[4] = 1'b1; mask[4] = 1'b1;
    tick("R1 edges");
    chk("R1 pins 4,183", {sum_hi, sum_lo}, (64'd1 << 45) | 64'd2);

    // R3 all pending
    int_sts = '1; mask = '1;
    tick("R3 all");
    chk("R3 all set", {sum_hi, sum_lo}, {18'd0, {46{1'b1}}});

    // R5 end of interrupt with pending work
    cfg_write(32'h0000_2000, "R5 eoi");
    chk("R5 irq dropped", {63'd0, irq}, 64'd0);
    tick("R5 after");
    chk("R5 irq back", {63'd0, irq}, 64'd1);
    // R4 EOI with summary cleared: irq stays low
    int_sts = '0; mask = '0; wake_sts = '0;
    tick("R4 idle");
    chk("R4 idle irq", {63'd0, irq}, 64'd0);

    // R8 enable off
    int_sts[10] = 1'b1; mask[10] = 1'b1;
    cfg_write(32'h0000_0007, "R8 cfg");
    db_wr = 1'b1;
    tick("R8 dbwr");
    chk("R8 no window", {63'd0, en_force_low[0]}, 64'd0);
    chk("R8 summary kept", {sum_hi, sum_lo}, 64'd4);

    // R10 length zero
    cfg_write(32'h0000_1000, "R10 cfg");
    db_wr = 1'b1;
    tick("R10 dbwr");
    chk("R10 no window", {63'd0, en_force_low[0]}, 64'd0);
    chk("R10 summary kept", {sum_hi, sum_lo}, 64'd4);

    // R7 window length 5, then R9 reload
    cfg_write(32'h0000_1005, "R7 cfg");
    db_wr = 1'b1;
    tick("R7 start");
    chk("R7 force on", {63'd0, en_force_low[0]}, 64'd1);
    chk("R7 quiet", {sum_hi, sum_lo}, 64'd0);
    repeat (2) tick("R9 mid");
    db_wr = 1'b1;
    tick("R9 reload");
    win = 1;
    while (en_force_low[0] && win < 20) begin
      tick("R9 count");
      if (en_force_low[0]) win++;
    end
    chk("R9 window after reload", win, 5);
    tick("R7 resume");
    chk("R7 summary back", {sum_hi, sum_lo}, 64'd4);

    // random phase
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < NP; i++) begin
        int_sts[i]  = ($urandom % 24) == 0;
        wake_sts[i] = ($urandom % 40) == 0;
        mask[i]     = ($urandom % 2) == 0;
      end
      if (($urandom % 8) == 0) begin
        int_sts = '0; wake_sts = '0;
      end
      db_wr = ($urandom % 20) == 0;
      if (($urandom % 25) == 0) begin
        cfg_wr = 1'b1;
        cfg_wdata = ($urandom & 32'hFFFF_C000) | ($urandom % 16)
                    | ((($urandom % 4) != 0) ? 32'h1000 : 32'h0);
      end else if (($urandom % 10) == 0) begin
        cfg_wr = 1'b1;
        cfg_wdata = {18'd0, 1'b1, m_en, m_len};
      end
      tick("R1 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule